// File: doc/BRIEF.md
# Stepped-Length Test Packet Generator

This block produces an endless series of test packets on a 64-bit streaming output made of data, valid, last and a per-byte keep mask, with a ready input from the sink. It is meant for link soak tests. A checker at the far end of a loopback can predict every byte of every packet, so it can tell a corrupted packet from a lost one and can detect a gap between packets that has been squeezed away.

Two length modes are available. In stepped mode, packet lengths climb from 100 to 1800 bytes in 100-byte steps and then start again at 100. In constant mode every packet has one fixed length, set by a parameter. Every packet carries the same payload pattern, which restarts with each packet: the first word has lanes 1 through 8, and every later word adds one to each lane. Packets are separated by a fixed number of idle word times, two by default, which is 16 bytes on a 156.25 MHz data clock. The generator also outputs the length and the sequence index of the packet it is sending, so that a checker can align itself.

Top module: `steppkt_gen`

## Requirements
- R1: While rst_n is low, and after reset until the first packet starts, tvalid is 0, tlast is 0, tkeep is 0, cur_len is 0 and seq_idx is 0.
- R2: In stepped mode the packet with sequence index i (0 to 17) is 100 + 100·i bytes long. While that packet is on the bus, cur_len shows its length and seq_idx shows i. Each stepped packet takes the next index.
- R3: The stepped packet after the 1800-byte packet is 100 bytes long and has seq_idx 0.
- R4: The first beat of every packet carries 0x0102030405060708. Byte lane k is tdata[8k+7:8k], so lane 0 holds 0x08.
- R5: Each later beat of a packet equals the previous beat with 1 added to each byte lane separately, modulo 256, with no carry between lanes.
- R6: A packet of L bytes takes ceil(L/8) beats and tvalid stays high between its first and last beat. tlast is 1 only on the final beat. Every other beat has tkeep = 0xFF. The final beat has the low n bits of tkeep set, where n = L mod 8, or all 8 bits when n = 0. Idle cycles show tkeep 0 and tlast 0.
- R7: With enable held high, exactly GAP_WORDS cycles (default 2) with tvalid low separate the handshake of a last beat from the first beat of the next packet. tready has no effect during idle cycles.
- R8: While tvalid is 1 and tready is 0, tdata, tkeep and tlast hold their values into the next cycle.
- R9: In constant mode every packet is CONST_LEN bytes long (default 300), with seq_idx 0 and the payload of R4 and R5.
- R10: A packet starts only if enable was 1 at the starting clock edge. Dropping enable lets the packet in flight finish. step_mode is sampled when a packet starts, and the first stepped packet after any constant-mode packet has index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows new packets to start |
| step_mode | input | 1 | 1 selects stepped lengths, 0 selects constant length |
| tready | input | 1 | Sink accepts the current beat |
| tvalid | output | 1 | Beat on tdata is valid |
| tdata | output | 64 | Payload word, byte lane k at bits 8k+7:8k |
| tkeep | output | 8 | Valid-byte mask, bit k for lane k |
| tlast | output | 1 | Final beat of the packet |
| cur_len | output | LEN_W (11) | Length in bytes of the current or most recent packet |
| seq_idx | output | IDX_W (5) | Sequence index of the packet being sent |

## Verification
A corrupted beat counter shows up at the ports within the same packet, as tlast on the wrong beat or a short last-beat keep mask. A wrong sequence index, or a wrong mode capture, shows up on the first beat of the next packet, where cur_len, seq_idx and the number of beats no longer match the expected stepped order. A payload register that skips or carries between lanes breaks the lane pattern on the very next accepted beat. A gap counter that is off by one moves the next first beat by one cycle, and the idle count is checked on every packet boundary.

// File: rtl/steppkt_pkg.sv
package steppkt_pkg;

    localparam int unsigned WORD_LANES = 8;
    localparam int unsigned LANE_W     = 8;
    localparam int unsigned WORD_W     = WORD_LANES * LANE_W;

    typedef logic [WORD_W-1:0]     word_t;
    typedef logic [WORD_LANES-1:0] keep_t;

    // Opening word of every packet: lane k holds WORD_LANES - k.
    function automatic word_t first_word();
        word_t w;
        for (int k = 0; k < int'(WORD_LANES); k++) begin
            w[k*LANE_W +: LANE_W] = LANE_W'(int'(WORD_LANES) - k);
        end
        return w;
    endfunction

    // Each lane gains one, wrapping inside the lane.
    function automatic word_t lanes_plus_one(word_t w);
        word_t r;
        for (int k = 0; k < int'(WORD_LANES); k++) begin
            r[k*LANE_W +: LANE_W] = w[k*LANE_W +: LANE_W] + LANE_W'(1);
        end
        return r;
    endfunction

endpackage

// File: rtl/steppkt_lane_inc.sv
module steppkt_lane_inc
    import steppkt_pkg::*;
(
    input  word_t word_i,
    output word_t word_o
);

    for (genvar k = 0; k < int'(WORD_LANES); k++) begin : g_lane
        assign word_o[k*LANE_W +: LANE_W] = word_i[k*LANE_W +: LANE_W] + LANE_W'(1);
    end

endmodule

// File: rtl/steppkt_len_calc.sv
module steppkt_len_calc
    import steppkt_pkg::*;
#(
    parameter int unsigned LEN_MIN   = 100,
    parameter int unsigned LEN_STEP  = 100,
    parameter int unsigned CONST_LEN = 300,
    parameter int unsigned LEN_W     = 11,
    parameter int unsigned IDX_W     = 5
) (
    input  logic [IDX_W-1:0] idx_i,
    input  logic             stepped_i,
    output logic [LEN_W-1:0] len_o,
    output logic [LEN_W-1:0] beats_o,
    output keep_t            last_keep_o
);

    localparam int unsigned SH = $clog2(WORD_LANES);

    int unsigned    len_full;
    logic [SH-1:0]  rem;

    always_comb begin
        if (stepped_i) begin
            len_full = LEN_MIN + 32'(idx_i) * LEN_STEP;
        end else begin
            len_full = CONST_LEN;
        end
        len_o   = LEN_W'(len_full);
        beats_o = LEN_W'((len_full + WORD_LANES - 1) >> SH);
        rem     = len_full[SH-1:0];
        for (int k = 0; k < int'(WORD_LANES); k++) begin
            last_keep_o[k] = (rem == '0) || (SH'(k) < rem);
        end
    end

endmodule

// File: rtl/steppkt_gen.sv
module steppkt_gen
    import steppkt_pkg::*;
#(
    parameter int unsigned LEN_MIN   = 100,
    parameter int unsigned LEN_STEP  = 100,
    parameter int unsigned LEN_MAX   = 1800,
    parameter int unsigned CONST_LEN = 300,
    parameter int unsigned GAP_WORDS = 2,
    parameter int unsigned NUM_STEPS = (LEN_MAX - LEN_MIN) / LEN_STEP + 1,
    parameter int unsigned IDX_W     = (NUM_STEPS > 1) ? $clog2(NUM_STEPS) : 1,
    parameter int unsigned LEN_W     = $clog2(((LEN_MAX > CONST_LEN) ? LEN_MAX : CONST_LEN) + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             step_mode,
    input  logic             tready,
    output logic             tvalid,
    output logic [63:0]      tdata,
    output logic [7:0]       tkeep,
    output logic             tlast,
    output logic [LEN_W-1:0] cur_len,
    output logic [IDX_W-1:0] seq_idx
);

    localparam int unsigned GAP_W = $clog2(GAP_WORDS + 1);

    typedef struct packed {
        logic             busy;
        logic [GAP_W-1:0] gap;
        word_t            word;
        logic [LEN_W-1:0] left;
        logic [LEN_W-1:0] len;
        logic [IDX_W-1:0] idx;
        logic             stepped;
        keep_t            keep_last;
    } state_t;

    state_t st_q, st_d;

    logic [LEN_W-1:0] calc_len;
    logic [LEN_W-1:0] calc_beats;
    keep_t            calc_keep;
    word_t            word_next;

    steppkt_len_calc #(
        .LEN_MIN   (LEN_MIN),
        .LEN_STEP  (LEN_STEP),
        .CONST_LEN (CONST_LEN),
        .LEN_W     (LEN_W),
        .IDX_W     (IDX_W)
    ) u_len (
        .idx_i       (st_q.idx),
        .stepped_i   (step_mode),
        .len_o       (calc_len),
        .beats_o     (calc_beats),
        .last_keep_o (calc_keep)
    );

    steppkt_lane_inc u_inc (
        .word_i (st_q.word),
        .word_o (word_next)
    );

    logic on_last;
    assign on_last = (st_q.left == LEN_W'(1));

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            // idle: count gap cycles, start when gap met and enabled
            if ((st_q.gap >= GAP_W'(GAP_WORDS)) && enable) begin
                st_d.busy      = 1'b1;
                st_d.word      = first_word();
                st_d.left      = calc_beats;
                st_d.len       = calc_len;
                st_d.stepped   = step_mode;
                st_d.keep_last = calc_keep;
                if (!step_mode) begin
                    st_d.idx = '0;
                end
            end else if (st_q.gap < GAP_W'(GAP_WORDS)) begin
                st_d.gap = st_q.gap + GAP_W'(1);
            end
        end else if (tready) begin
            if (on_last) begin
                st_d.busy = 1'b0;
                st_d.gap  = GAP_W'(1);
                if (st_q.stepped && (st_q.idx != IDX_W'(NUM_STEPS - 1))) begin
                    st_d.idx = st_q.idx + IDX_W'(1);
                end else begin
                    st_d.idx = '0;
                end
            end else begin
                st_d.word = word_next;
                st_d.left = st_q.left - LEN_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.busy      <= 1'b0;
            st_q.gap       <= GAP_W'(GAP_WORDS);
            st_q.word      <= '0;
            st_q.left      <= '0;
            st_q.len       <= '0;
            st_q.idx       <= '0;
            st_q.stepped   <= 1'b0;
            st_q.keep_last <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tvalid  = st_q.busy;
    assign tdata   = st_q.word;
    assign tlast   = st_q.busy && on_last;
    assign tkeep   = !st_q.busy ? '0 : (on_last ? st_q.keep_last : '1);
    assign cur_len = st_q.len;
    assign seq_idx = st_q.idx;

endmodule

// File: rtl/steppkt_chk.sv
module steppkt_chk
    import steppkt_pkg::*;
#(
    parameter int unsigned GAP_WORDS = 2,
    parameter int unsigned NUM_STEPS = 18,
    parameter int unsigned IDX_W     = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tvalid,
    input logic             tready,
    input logic             tlast,
    input word_t            tdata,
    input keep_t            tkeep,
    input logic [IDX_W-1:0] seq_idx
);

    localparam int unsigned GAP_W = $clog2(GAP_WORDS + 1);

    logic [GAP_W-1:0] idle_q;
    logic             seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_q <= '0;
            seen_q <= 1'b0;
        end else begin
            if (tvalid) begin
                idle_q <= '0;
            end else if (idle_q < GAP_W'(GAP_WORDS)) begin
                idle_q <= idle_q + GAP_W'(1);
            end
            if (tvalid && tready && tlast) begin
                seen_q <= 1'b1;
            end
        end
    end

    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        tvalid && !tready |=> tvalid && $stable(tdata) && $stable(tkeep) && $stable(tlast)); // R8

    AST_FIRST_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tvalid) |-> tdata == first_word()); // R4

    AST_LANE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tvalid && tready && !tlast |=> tvalid && (tdata == lanes_plus_one($past(tdata)))); // R5

    AST_KEEP_BODY: assert property (@(posedge clk) disable iff (!rst_n)
        tvalid && !tlast |-> tkeep == '1); // R6

    AST_KEEP_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
        tvalid |-> tkeep[0] && ((tkeep & keep_t'(tkeep + 1'b1)) == '0)); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !tvalid |-> (tkeep == '0) && !tlast); // R6

    AST_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tvalid) && seen_q |-> idle_q >= GAP_W'(GAP_WORDS)); // R7

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_idx <= IDX_W'(NUM_STEPS - 1)); // R2

endmodule

bind steppkt_gen steppkt_chk #(
    .GAP_WORDS (GAP_WORDS),
    .NUM_STEPS (NUM_STEPS),
    .IDX_W     (IDX_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tvalid  (tvalid),
    .tready  (tready),
    .tlast   (tlast),
    .tdata   (tdata),
    .tkeep   (tkeep),
    .seq_idx (seq_idx)
);

// File: tb/sim_steppkt_gen.sv
module sim_steppkt_gen;

    localparam int MIN_L   = 100;
    localparam int STEP_L  = 100;
    localparam int STEPS   = 18;
    localparam int FIX_L   = 300;
    localparam int GAP     = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        step_mode = 1'b0;
    logic        tready = 1'b0;
    logic        tvalid;
    logic [63:0] tdata;
    logic [7:0]  tkeep;
    logic        tlast;
    logic [10:0] cur_len;
    logic [4:0]  seq_idx;

    steppkt_gen u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .step_mode (step_mode),
        .tready    (tready),
        .tvalid    (tvalid),
        .tdata     (tdata),
        .tkeep     (tkeep),
        .tlast     (tlast),
        .cur_len   (cur_len),
        .seq_idx   (seq_idx)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    function automatic logic [63:0] bump(logic [63:0] w);
        logic [63:0] r;
        for (int k = 0; k < 8; k++) r[8*k +: 8] = w[8*k +: 8] + 8'd1;
        return r;
    endfunction

    function automatic logic [7:0] last_mask(int len);
        int n = len % 8;
        if (n == 0) return 8'hFF;
        return 8'((1 << n) - 1);
    endfunction

    // ---------------- monitor: reference model of the stream ----------------
    bit          mon_on = 1'b0;
    bit          in_pkt = 1'b0;
    bit          first_done = 1'b0;
    bit          idle_en_low = 1'b0;
    bit          en_prev = 1'b0;
    bit          mode_prev = 1'b0;
    bit          pkt_stepped = 1'b0;
    bit          stall_prev = 1'b0;
    int          beat, nbeats, exp_len, prev_len = 0, exp_idx = 0, idle_run = 0;
    int          n_pkts = 0;
    logic [63:0] exp_word, held_data;
    logic [7:0]  held_keep;
    logic        held_last;

    always @(negedge clk) begin
        if (mon_on) begin
            if (tvalid) begin
                if (stall_prev) begin
                    check(tdata == held_data && tkeep == held_keep && tlast == held_last,
                          "R8", "stalled beat changed", tdata, held_data);
                end
                if (!in_pkt) begin
                    check(en_prev, "R10", "packet began while disabled", 0, 1);
                    if (first_done) begin
                        if (!idle_en_low)
                            check(idle_run == GAP, "R7", "idle cycles between packets", idle_run, GAP);
                        else
                            check(idle_run >= GAP, "R7", "idle cycles (enable dipped)", idle_run, GAP);
                    end
                    pkt_stepped = mode_prev;
                    exp_len = pkt_stepped ? MIN_L + STEP_L * exp_idx : FIX_L;
                    if (pkt_stepped) begin
                        check(cur_len == exp_len, "R2", "stepped length", cur_len, exp_len);
                        check(seq_idx == exp_idx, "R2", "sequence index", seq_idx, exp_idx);
                        if (prev_len == MIN_L + STEP_L * (STEPS - 1))
                            check(cur_len == MIN_L && seq_idx == 0, "R3", "wrap to first step", cur_len, MIN_L);
                    end else begin
                        check(cur_len == FIX_L, "R9", "constant length", cur_len, FIX_L);
                        check(seq_idx == 0, "R9", "constant index", seq_idx, 0);
                    end
                    nbeats   = (exp_len + 7) / 8;
                    beat     = 0;
                    exp_word = 64'h0102030405060708;
                    in_pkt   = 1'b1;
                    check(tdata == exp_word, "R4", "first word", tdata, exp_word);
                end else begin
                    check(tdata == exp_word, "R5", "payload word", tdata, exp_word);
                end
                check(tlast == (beat == nbeats - 1), "R6", "tlast position", tlast, (beat == nbeats - 1));
                check(tkeep == ((beat == nbeats - 1) ? last_mask(exp_len) : 8'hFF),
                      "R6", "keep mask", tkeep,
                      (beat == nbeats - 1) ? last_mask(exp_len) : 8'hFF);
                stall_prev = !tready;
                held_data  = tdata;
                held_keep  = tkeep;
                held_last  = tlast;
                if (tready) begin
                    if (beat == nbeats - 1) begin
                        in_pkt      = 1'b0;
                        first_done  = 1'b1;
                        idle_run    = 0;
                        idle_en_low = 1'b0;
                        prev_len    = pkt_stepped ? exp_len : 0;
                        if (pkt_stepped) exp_idx = (exp_idx == STEPS - 1) ? 0 : exp_idx + 1;
                        else exp_idx = 0;
                        n_pkts++;
                    end else begin
                        beat++;
                        exp_word = bump(exp_word);
                    end
                end
            end else begin
                if (in_pkt) check(1'b0, "R6", "tvalid dropped mid-packet", 0, 1);
                check(tkeep == 8'h00 && !tlast, "R6", "idle keep/last", {tlast, tkeep}, 0);
                stall_prev = 1'b0;
                idle_run++;
                if (!en_prev || !enable) idle_en_low = 1'b1;
            end
            en_prev   = enable;
            mode_prev = step_mode;
        end
    end

    // ---------------- stimulus ----------------
    int dis_cnt = 0;

    task automatic rand_cycle(input int ready_pct, input bit allow_dis);
        @(posedge clk); #1;
        tready = (($urandom % 100) < ready_pct);
        if (allow_dis) begin
            if (dis_cnt > 0) begin
                dis_cnt--;
                enable = (dis_cnt == 0);
            end else if (($urandom % 700) == 0) begin
                dis_cnt = 10 + ($urandom % 30);
                enable  = 1'b0;
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(tvalid == 0 && tlast == 0 && tkeep == 0, "R1", "outputs in reset", {tvalid, tlast, tkeep}, 0);
        check(cur_len == 0 && seq_idx == 0, "R1", "len/index in reset", {cur_len, seq_idx}, 0);
        @(posedge clk); #1; rst_n = 1'b1;
        @(negedge clk); mon_on = 1'b1;
        // stays quiet with enable low
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check(tvalid == 0, "R10", "no packet while disabled", tvalid, 0);
            check(cur_len == 0 && seq_idx == 0, "R1", "idle after reset", {cur_len, seq_idx}, 0);
        end
        // full stepped cycle and wrap, sink always ready
        @(posedge clk); #1; step_mode = 1'b1; tready = 1'b1; enable = 1'b1;
        while (n_pkts < 20) begin @(posedge clk); #1; end
        // random backpressure and occasional enable dips
        while (n_pkts < 45) rand_cycle(70, 1'b1);
        dis_cnt = 0; enable = 1'b1;
        // constant mode
        @(posedge clk); #1; step_mode = 1'b0;
        while (n_pkts < 56) rand_cycle(60, 1'b0);
        // back to stepped: must restart at index 0
        @(posedge clk); #1; step_mode = 1'b1;
        while (n_pkts < 62) rand_cycle(85, 1'b0);
        // drop enable mid-packet: packet finishes, nothing new starts
        while (!(tvalid && !tlast)) begin @(posedge clk); #1; end
        enable = 1'b0; tready = 1'b1;
        repeat (300) @(posedge clk);
        @(negedge clk);
        check(tvalid == 0 && !in_pkt, "R10", "stopped after in-flight packet", tvalid, 0);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: run did not complete, actual=%0d expected=%0d packets", n_pkts, 62);
        finish_run();
    end

endmodule